// File: doc/BRIEF.md
# System Exception Status Unit

This unit gathers fault pulses that the CPU datapath raises and turns them into a non-maskable exception request. There are four sources: stack overflow, illegal instruction, divide-by-zero and divide overflow. Each source owns one sticky bit in a status register. When a new fault arrives from a source whose bit is clear, that bit is set and a single request is raised towards the CPU. All sources share one vector address, and the global interrupt enable has no effect on them.

Software reads the status register and clears bits by writing ones to them. While a bit stays set, further pulses from that source are dropped, so the same fault cannot re-enter the handler over and over. The unit also decides priority against the maskable interrupt path: a pending system exception holds back the forwarding of any maskable request. The register stack push and the vector fetch happen outside this unit. They appear here only as the request strobe, the vector output and the acknowledge input.

Top module: `sesu_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `status_o` is 0, `exc_req_o` is low and `vec_addr_o` is 0.
- R2: The status bits map to sources as follows: bit 0 is stack overflow, bit 1 is illegal instruction, bit 2 is divide-by-zero and bit 3 is divide overflow. A pulse on `fault_i[i]` while bit i is clear sets bit i at the next clock edge.
- R3: With `wr_en_i` high, every status bit whose `wr_data_i` bit is 1 is clear after the edge. Bits where `wr_data_i` is 0 keep their value.
- R4: A pulse on `fault_i[i]` while bit i is already set changes no status bit. It also raises no request: if `exc_req_o` was low and no other unblocked fault arrives, it stays low.
- R5: Any cycle with at least one unblocked fault raises `exc_req_o` at the next edge. This holds however many sources fire together, and all of their bits are set in that same edge.
- R6: Once high, `exc_req_o` stays high until it is sampled together with `exc_ack_i` high, and it goes low at that edge. If an unblocked fault arrives in the same cycle as the acknowledge, the request stays high.
- R7: `vec_addr_o` equals 0x000008 whenever `exc_req_o` is high and 0 otherwise.
- R8: The global enable input `gie_i` has no influence on status bits, on `exc_req_o` or on `vec_addr_o`.
- R9: `int_fwd_o` equals `int_req_i` AND `gie_i` AND NOT `exc_req_o`, combinationally. A pending system exception takes precedence over any maskable interrupt.
- R10: Blocking uses the status value held before the edge. If a write-1 clears bit i in the same cycle as a pulse on `fault_i[i]` while that bit was set, the bit ends clear and the pulse is dropped. A pulse on a clear bit together with a write-1 to it leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_i | input | NUM_SRC | One-cycle fault pulses, one per source |
| wr_en_i | input | 1 | Status register write strobe |
| wr_data_i | input | NUM_SRC | Write data; 1 clears the matching status bit |
| exc_ack_i | input | 1 | CPU accepts the pending exception entry |
| gie_i | input | 1 | Global maskable interrupt enable |
| int_req_i | input | 1 | Request from the maskable interrupt logic |
| status_o | output | NUM_SRC | Per-source sticky status bits |
| exc_req_o | output | 1 | Exception entry request to the CPU |
| vec_addr_o | output | ADDR_W | Shared vector address while requesting |
| int_fwd_o | output | 1 | Maskable request passed on to the CPU |

## Verification
The bench walks every starting status value against every fault pattern on the four sources. This separates three kinds of pulse: pulses on set bits, which must be dropped with no request; pulses on clear bits, which must set the bit and raise exactly one request; and mixed patterns, where only the fresh bits may count. The global enable and the maskable request are varied across the sweep. This shows that the enable never reaches the exception path and that forwarding is gated by a pending request. Directed cases cover requests held without an acknowledge, an acknowledge that coincides with a new fault, partial write-1 masks, and a clear that coincides with a fault on the same bit.

// File: rtl/sesu_pkg.sv
package sesu_pkg;

    localparam int unsigned SRC_COUNT  = 4;
    localparam int unsigned VEC_WIDTH  = 24;
    localparam logic [VEC_WIDTH-1:0] SHARED_VEC = 24'h000008;

    // source positions inside the status register
    typedef enum int unsigned {
        SRC_STACK_OVF  = 0,
        SRC_BAD_OPCODE = 1,
        SRC_DIV_ZERO   = 2,
        SRC_DIV_OVF    = 3
    } src_pos_e;

    // entry request state
    typedef enum logic {
        REQ_IDLE = 1'b0,
        REQ_PEND = 1'b1
    } req_state_e;

    // per-bit update decided in one cycle
    typedef struct packed {
        logic take;   // unblocked fault
        logic wipe;   // write-1 clear
    } bit_upd_t;

    function automatic logic bit_next(logic cur, bit_upd_t u);
        if (u.take)      return 1'b1;
        else if (u.wipe) return 1'b0;
        else             return cur;
    endfunction

endpackage

// File: rtl/sesu_status.sv
module sesu_status #(
    parameter int unsigned NUM_SRC = sesu_pkg::SRC_COUNT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] fault_i,
    input  logic               wr_en_i,
    input  logic [NUM_SRC-1:0] wr_data_i,
    output logic [NUM_SRC-1:0] status_o,
    output logic [NUM_SRC-1:0] accept_o
);
    import sesu_pkg::*;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        logic     bit_q;
        bit_upd_t upd;

        // blocking decision uses the value held before the edge
        always_comb begin
            upd.take = fault_i[g] & ~bit_q;
            upd.wipe = wr_en_i & wr_data_i[g];
        end

        always_ff @(posedge clk) begin
            if (rst) bit_q <= 1'b0;
            else     bit_q <= bit_next(bit_q, upd);
        end

        assign status_o[g] = bit_q;
        assign accept_o[g] = upd.take;
    end

endmodule

// File: rtl/sesu_req_ctl.sv
module sesu_req_ctl (
    input  logic clk,
    input  logic rst,
    input  logic any_new_i,
    input  logic ack_i,
    output logic req_o
);
    import sesu_pkg::*;

    req_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE: if (any_new_i)          state_d = REQ_PEND;
            REQ_PEND: if (ack_i && !any_new_i) state_d = REQ_IDLE;
            default:                           state_d = REQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= REQ_IDLE;
        else     state_q <= state_d;
    end

    assign req_o = (state_q == REQ_PEND);

endmodule

// File: rtl/sesu_arb.sv
module sesu_arb #(
    parameter int unsigned ADDR_W = sesu_pkg::VEC_WIDTH,
    parameter logic [ADDR_W-1:0] VEC_ADDR = ADDR_W'(sesu_pkg::SHARED_VEC)
) (
    input  logic              exc_req_i,
    input  logic              int_req_i,
    input  logic              gie_i,
    output logic              int_fwd_o,
    output logic [ADDR_W-1:0] vec_addr_o
);
    // exception path never looks at gie_i
    assign vec_addr_o = exc_req_i ? VEC_ADDR : '0;
    assign int_fwd_o  = int_req_i & gie_i & ~exc_req_i;

endmodule

// File: rtl/sesu_top.sv
module sesu_top #(
    parameter int unsigned NUM_SRC = sesu_pkg::SRC_COUNT,
    parameter int unsigned ADDR_W  = sesu_pkg::VEC_WIDTH,
    parameter logic [ADDR_W-1:0] VEC_ADDR = ADDR_W'(sesu_pkg::SHARED_VEC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] fault_i,
    input  logic               wr_en_i,
    input  logic [NUM_SRC-1:0] wr_data_i,
    input  logic               exc_ack_i,
    input  logic               gie_i,
    input  logic               int_req_i,
    output logic [NUM_SRC-1:0] status_o,
    output logic               exc_req_o,
    output logic [ADDR_W-1:0]  vec_addr_o,
    output logic               int_fwd_o
);
    logic [NUM_SRC-1:0] accept;

    sesu_status #(.NUM_SRC(NUM_SRC)) u_status (
        .clk       (clk),
        .rst       (rst),
        .fault_i   (fault_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .status_o  (status_o),
        .accept_o  (accept)
    );

    sesu_req_ctl u_req (
        .clk       (clk),
        .rst       (rst),
        .any_new_i (|accept),
        .ack_i     (exc_ack_i),
        .req_o     (exc_req_o)
    );

    sesu_arb #(.ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)) u_arb (
        .exc_req_i  (exc_req_o),
        .int_req_i  (int_req_i),
        .gie_i      (gie_i),
        .int_fwd_o  (int_fwd_o),
        .vec_addr_o (vec_addr_o)
    );

endmodule

// File: rtl/sesu_checker.sv
module sesu_checker #(
    parameter int unsigned NUM_SRC = 4,
    parameter int unsigned ADDR_W  = 24,
    parameter logic [ADDR_W-1:0] VEC_ADDR = '0
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] fault_i,
    input logic               wr_en_i,
    input logic [NUM_SRC-1:0] wr_data_i,
    input logic               exc_ack_i,
    input logic               gie_i,
    input logic               int_req_i,
    input logic [NUM_SRC-1:0] status_o,
    input logic               exc_req_o,
    input logic [ADDR_W-1:0]  vec_addr_o,
    input logic               int_fwd_o
);
    AST_RESET_CLEAN: assert property (@(posedge clk) rst |=> (status_o == '0 && !exc_req_o)); // R1
    AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> status_o == ($past(status_o) | $past(fault_i))); // R2
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> (status_o & $past(wr_data_i & status_o)) == '0); // R3
    AST_BLOCKED_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        (!exc_req_o && (fault_i & ~status_o) == '0) |=> !exc_req_o); // R4
    AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(exc_req_o) |-> $past((fault_i & ~status_o) != '0)); // R5
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (exc_req_o && !exc_ack_i) |=> exc_req_o); // R6
    AST_VEC_OUT: assert property (@(posedge clk) disable iff (rst)
        vec_addr_o == (exc_req_o ? VEC_ADDR : '0)); // R7
    AST_EXC_FIRST: assert property (@(posedge clk) disable iff (rst)
        exc_req_o |-> !int_fwd_o); // R9
endmodule

bind sesu_top sesu_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)) u_chk (
    .clk(clk), .rst(rst), .fault_i(fault_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .exc_ack_i(exc_ack_i), .gie_i(gie_i), .int_req_i(int_req_i), .status_o(status_o),
    .exc_req_o(exc_req_o), .vec_addr_o(vec_addr_o), .int_fwd_o(int_fwd_o)
);

// File: tb/sesu_top_tb_top.sv
module sesu_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [23:0] VEC = 24'h000008;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  fault = '0;
    logic        wr = 1'b0;
    logic [3:0]  wdat = '0;
    logic        ack = 1'b0;
    logic        gie = 1'b0;
    logic        ireq = 1'b0;
    logic [3:0]  status;
    logic        req;
    logic [23:0] vec;
    logic        fwd;

    int errs = 0;
    int checks = 0;
    logic [3:0] m_st = '0;
    logic       m_req = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sesu_top dut_i (
        .clk(clk), .rst(rst), .fault_i(fault), .wr_en_i(wr), .wr_data_i(wdat),
        .exc_ack_i(ack), .gie_i(gie), .int_req_i(ireq), .status_o(status),
        .exc_req_o(req), .vec_addr_o(vec), .int_fwd_o(fwd)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive at negedge, check combinational forward, then check registered outputs after edge
    task automatic step(input logic [3:0] f, input logic w, input logic [3:0] wd,
                        input logic a, input logic g, input logic ir, input string tag);
        logic [3:0] acc;
        fault = f; wr = w; wdat = wd; ack = a; gie = g; ireq = ir;
        #1;
        chk("R9 forward", {31'd0, fwd}, {31'd0, ir & g & ~m_req});
        acc   = f & ~m_st;
        m_st  = (m_st & ~(w ? wd : 4'h0)) | acc;
        m_req = (acc != 4'h0) | (m_req & ~a);
        @(posedge clk);
        #1;
        chk({tag, " status"}, {28'd0, status}, {28'd0, m_st});
        chk({tag, " request"}, {31'd0, req}, {31'd0, m_req});
        chk("R7 vector", {8'd0, vec}, m_req ? {8'd0, VEC} : 32'd0);
        fault = '0; wr = 1'b0; wdat = '0; ack = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        // reset with faults pending, which must be ignored
        fault = 4'hF; wr = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 status in reset", {28'd0, status}, 32'd0);
        chk("R1 request in reset", {31'd0, req}, 32'd0);
        chk("R1 vector in reset", {8'd0, vec}, 32'd0);
        fault = '0;
        rst = 1'b0;
        @(negedge clk);
        chk("R1 status after reset", {28'd0, status}, 32'd0);
        chk("R1 request after reset", {31'd0, req}, 32'd0);

        // sweep of every starting state against every fault pattern
        for (int init = 0; init < 16; init++) begin
            for (int pat = 0; pat < 16; pat++) begin
                logic g;
                logic ir;
                g  = pat[0] ^ init[1];
                ir = pat[1] | init[0];
                step(4'h0, 1'b1, 4'hF, 1'b1, g, ir, "R3 clear all");
                step(4'(init), 1'b0, 4'h0, 1'b0, g, ir, "R2 preset");
                step(4'h0, 1'b0, 4'h0, 1'b1, ~g, ir, "R6 ack");
                step(4'(pat), 1'b0, 4'h0, 1'b0, g, ir, "R4 R5 R8 sweep");
                step(4'h0, 1'b0, 4'h0, 1'b0, ~g, 1'b1, "R6 hold");
                step(4'h0, 1'b0, 4'h0, 1'b1, g, 1'b1, "R6 release");
            end
        end

        // partial write-1 mask
        step(4'h0, 1'b1, 4'hF, 1'b1, 1'b1, 1'b0, "R3 clear all");
        step(4'hF, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, "R5 all together");
        step(4'h0, 1'b1, 4'b0101, 1'b1, 1'b1, 1'b0, "R3 partial");
        chk("R3 zero bits kept", {28'd0, status}, 32'hA);

        // ack coincident with new fault keeps request
        step(4'b0001, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, "R5 refire");
        step(4'b0100, 1'b0, 4'h0, 1'b1, 1'b0, 1'b1, "R6 ack with new");
        chk("R6 request kept", {31'd0, req}, 32'd1);
        step(4'h0, 1'b0, 4'h0, 1'b1, 1'b1, 1'b1, "R6 release");

        // clear and fault on the same bit in one cycle
        step(4'h0, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0, "R3 clear all");
        step(4'b0001, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, "R10 preset");
        step(4'h0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, "R10 ack");
        step(4'b0011, 1'b1, 4'b0011, 1'b0, 1'b0, 1'b0, "R10 same cycle");
        chk("R10 result bits", {28'd0, status}, 32'h2);
        chk("R10 request from fresh bit", {31'd0, req}, 32'd1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule